// File: doc/BRIEF.md
# Two-Step Software Reset Sequencer

This block watches the instruction frames that a serial front end decodes, each frame bounded by chip-select. It looks for a fixed two-frame sequence: an enable-reset opcode (66h) followed by a reset opcode (99h), each sent as a separate frame of exactly one byte. When the pair completes, the block sends a one-cycle abort to stop any internal operation in progress, such as a busy authentication computation. In the same cycle it sends a one-cycle reset to all volatile state. It then closes the instruction path for a fixed lockout of `LOCK_CYCLES` system clocks. By default this is 7500 cycles, which is 30 µs at 250 MHz.

The front end gives the block the chip-select level and a strobe for each received serial bit. It also gives a decoded-opcode strobe with the opcode byte. A frame counts only if exactly eight bits arrived before chip-select rose. A frame with any other bit count clears the enabled state and has no other effect. The sequence can be sent at any time, including while another internal operation is busy. Frames that arrive during the lockout are discarded.

Top module: `soft_reset_seq`

## Requirements
- R1: After the asynchronous reset, `rst_pulse_o` = 0, `abort_o` = 0 and `accept_o` = 1.
- R2: A valid frame with opcode 66h, followed by a valid frame with opcode 99h, asserts `rst_pulse_o` in the cycle that follows the first clock edge at which `cs_n` is high after the 99h frame. A valid frame is one in which `cs_n` was low, exactly 8 `bit_tick` strobes arrived and `op_valid` was seen.
- R3: `abort_o` is asserted in exactly the same cycles as `rst_pulse_o`.
- R4: `rst_pulse_o` and `abort_o` stay high for a single cycle only.
- R5: `accept_o` goes low in the same cycle in which `rst_pulse_o` rises. It stays low for exactly `LOCK_CYCLES` cycles and then returns to 1.
- R6: A valid frame with any opcode other than 99h or 66h, sent after 66h, clears the enabled state. A following 99h frame then gives no reset.
- R7: A frame with fewer or more than 8 bit strobes clears the enabled state, even when its opcode is 66h or 99h.
- R8: A 99h frame sent while the enabled state is clear gives no reset.
- R9: Frames that end while `accept_o` is 0 are ignored. They give no reset, and they do not set the enabled state for frames sent after the lockout.
- R10: A second valid 66h frame sent while enabled keeps the block enabled, so a 99h frame after it still gives a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low, synchronous to clk |
| bit_tick | input | 1 | One-cycle strobe for each received serial bit |
| op_valid | input | 1 | Decoded-opcode strobe |
| op_byte | input | 8 | Opcode byte, qualified by op_valid |
| rst_pulse_o | output | 1 | One-cycle reset to the volatile state |
| abort_o | output | 1 | One-cycle abort of the internal operation |
| accept_o | output | 1 | High when instructions may be accepted |

## Verification
A wrong enabled state shows on `rst_pulse_o` one cycle after chip-select rises on a 99h frame. The pulse either appears where it should not or is missing where it is expected. A wrong bit count has the same effect, so sequences that include a short frame and a long frame expose both faults within one frame. A wrong lockout counter shows on `accept_o` as a lockout that is one or more cycles too long or too short, and it appears at the end of the window. Enabled state left over from the lockout appears as a reset after a lone 99h frame sent after the window.

// File: rtl/soft_reset_pkg.sv
package soft_reset_pkg;
  localparam logic [7:0] OP_ARM  = 8'h66;
  localparam logic [7:0] OP_FIRE = 8'h99;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } arm_state_t;
endpackage

// File: rtl/frame_tracker.sv
module frame_tracker #(
  parameter int BYTE_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       bit_tick,
  input  logic       op_valid,
  input  logic [7:0] op_byte,
  output logic       frame_done,
  output logic       frame_ok,
  output logic [7:0] frame_op
);
  localparam int CW = $clog2(BYTE_BITS + 2);
  localparam logic [CW-1:0] SAT  = CW'(BYTE_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_BITS);

  logic          cs_q;
  logic [CW-1:0] bits_q, bits_d;
  logic          seen_q, seen_d;
  logic [7:0]    op_q, op_d;

  always_comb begin
    bits_d = bits_q;
    seen_d = seen_q;
    op_d   = op_q;
    if (cs_n) begin
      bits_d = '0;
      seen_d = 1'b0;
    end else begin
      if (bit_tick && (bits_q != SAT)) bits_d = bits_q + 1'b1;
      if (op_valid) begin
        seen_d = 1'b1;
        op_d   = op_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      bits_q <= '0;
      seen_q <= 1'b0;
      op_q   <= '0;
    end else begin
      cs_q   <= cs_n;
      bits_q <= bits_d;
      seen_q <= seen_d;
      op_q   <= op_d;
    end
  end

  assign frame_done = cs_n & ~cs_q;
  assign frame_ok   = (bits_q == FULL) & seen_q;
  assign frame_op   = op_q;

  // R7
  bits_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= SAT);
endmodule

// File: rtl/lock_timer.sv
module lock_timer #(
  parameter int LOCK_CYCLES = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int TW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [TW-1:0] LOAD = TW'(LOCK_CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  // R5
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/soft_reset_seq.sv
module soft_reset_seq #(
  parameter int LOCK_CYCLES = 7500,
  parameter int BYTE_BITS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       bit_tick,
  input  logic       op_valid,
  input  logic [7:0] op_byte,
  output logic       rst_pulse_o,
  output logic       abort_o,
  output logic       accept_o
);
  import soft_reset_pkg::*;

  logic       frame_done, frame_ok;
  logic [7:0] frame_op;
  logic       busy;
  logic       fire;
  arm_state_t st_q, st_d;
  logic       rst_q, abort_q;

  frame_tracker #(.BYTE_BITS(BYTE_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_tick(bit_tick),
    .op_valid(op_valid), .op_byte(op_byte),
    .frame_done(frame_done), .frame_ok(frame_ok), .frame_op(frame_op)
  );

  lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(fire), .busy(busy)
  );

  always_comb begin
    st_d = st_q;
    fire = 1'b0;
    if (busy) begin
      st_d = ST_IDLE;
    end else if (frame_done) begin
      if (frame_ok && frame_op == OP_FIRE && st_q == ST_ARMED) fire = 1'b1;
      st_d = (frame_ok && frame_op == OP_ARM) ? ST_ARMED : ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rst_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rst_q   <= fire;
      abort_q <= fire;
    end
  end

  assign rst_pulse_o = rst_q;
  assign abort_o     = abort_q;
  assign accept_o    = ~busy;

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse_o |=> !rst_pulse_o);
  // R3
  abort_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o == rst_pulse_o);
  // R5
  lock_on_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse_o |-> !accept_o);
  // R9
  no_fire_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_o |=> !rst_pulse_o);
endmodule

// File: tb/soft_reset_seq_test.sv
module soft_reset_seq_test;
  localparam int LOCK = 40;
  localparam int NV   = 15;
  // vector: {opcode[7:0], bit count[3:0], expected reset[0]}
  localparam logic [12:0] VEC [NV] = '{
    {8'h99, 4'd8, 1'b0},  // R8
    {8'h66, 4'd8, 1'b0},
    {8'h99, 4'd8, 1'b1},  // R2
    {8'h66, 4'd8, 1'b0},
    {8'h3C, 4'd8, 1'b0},  // R6
    {8'h99, 4'd8, 1'b0},
    {8'h66, 4'd8, 1'b0},
    {8'h66, 4'd7, 1'b0},  // R7 short
    {8'h99, 4'd8, 1'b0},
    {8'h66, 4'd8, 1'b0},
    {8'h99, 4'd9, 1'b0},  // R7 long
    {8'h99, 4'd8, 1'b0},
    {8'h66, 4'd8, 1'b0},
    {8'h66, 4'd8, 1'b0},  // R10
    {8'h99, 4'd8, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, cs_n, bit_tick, op_valid;
  logic [7:0] op_byte;
  logic rst_pulse_o, abort_o, accept_o;
  int checks = 0, errors = 0;
  logic s_rst, s_abt, s_acc;

  always #2 clk = ~clk;

  soft_reset_seq #(.LOCK_CYCLES(LOCK)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_tick(bit_tick),
    .op_valid(op_valid), .op_byte(op_byte),
    .rst_pulse_o(rst_pulse_o), .abort_o(abort_o), .accept_o(accept_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input int n);
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_tick = 1'b1;
      op_valid = (i == 7);
      op_byte  = op;
      @(negedge clk);
      bit_tick = 1'b0;
      op_valid = 1'b0;
    end
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    s_rst = rst_pulse_o;
    s_abt = abort_o;
    s_acc = accept_o;
  endtask

  task automatic measure_lock(input string req);
    int low = 0;
    if (!accept_o) low = 1;
    @(negedge clk);
    check("R4", rst_pulse_o, 0);
    if (!accept_o) low++;
    while (!accept_o && low < 4 * LOCK) begin
      @(negedge clk);
      if (!accept_o) low++;
    end
    check(req, low, LOCK);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; bit_tick = 1'b0; op_valid = 1'b0; op_byte = '0;
    repeat (3) @(negedge clk);
    check("R1 rst", rst_pulse_o, 0);
    check("R1 abort", abort_o, 0);
    check("R1 accept", accept_o, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][12:5], int'(VEC[v][4:1]));
      check($sformatf("R2/R6/R7/R8/R10 vec%0d reset", v), s_rst, VEC[v][0]);
      check($sformatf("R3 vec%0d abort", v), s_abt, VEC[v][0]);
      if (VEC[v][0]) measure_lock("R5 lock length");
    end

    // R9: frames inside lockout ignored
    send(8'h66, 8);
    send(8'h99, 8);
    check("R2 trigger", s_rst, 1);
    send(8'h66, 8);
    check("R9 arm in lock", s_acc, 0);
    send(8'h99, 8);
    check("R9 fire in lock", s_rst, 0);
    while (!accept_o) @(negedge clk);
    send(8'h99, 8);
    check("R9 no arm carried", s_rst, 0);
    check("R9 accept", s_acc, 1);

    // R1: asynchronous reset during lockout
    send(8'h66, 8);
    send(8'h99, 8);
    check("R3 abort", s_abt, 1);
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 accept on reset", accept_o, 1);
    @(negedge clk) rst_n = 1'b1;
    send(8'h99, 8);
    check("R8 after reset", s_rst, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule